// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block works next to a small processor pipeline and performs the hardware side of taking and leaving an exception. Two kinds of exception can enter: an address fault, and a floating-point trap. On entry the sequencer copies the live mode, interrupt-enable and carry bits into backup copies, then updates the live bits. It records a return PC and redirects fetch to a fixed vector address. It also raises a one-cycle pipeline flush. On a return request it reloads the live status bits from the backups and resumes fetch at the recorded return PC.

Floating-point cause flags from the arithmetic unit are qualified against a per-cause enable mask. The unimplemented-operation flag traps regardless of the mask. A qualified floating-point trap that cannot be taken at once stays pending until the sequencer is free. Between exceptions, the pipeline can load the live status bits through a plain write port.

Top module: `trap_sequencer`

## Requirements
- R1: While reset is active and after it is released, the live status bits, backup status bits and return PC are 0, and neither `redir_valid` nor `pipe_flush` is asserted.
- R2: On any exception entry, the backup status bits take the values the live status bits had just before the entry, at the same clock edge at which the entry is taken.
- R3: On any exception entry, the live mode bit (`stat[2]`) keeps its value, while the live interrupt-enable (`stat[1]`) and carry (`stat[0]`) bits become 0.
- R4: An address-fault entry asserts `redir_valid` and `pipe_flush` in the cycle after the request, with `redir_addr` equal to the address-fault vector (default 0x0000_0030).
- R5: An address-fault entry stores the faulting PC with its two low bits cleared as the return PC (a fault at 0x06 stores 0x04).
- R6: A floating-point trap is qualified only when `fp_valid` is high and either `fp_unimpl` is high, or some bit i has both `fp_cause[i]` and `fp_en[i]` set. The cause bits are: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact. A cause that is not enabled has no effect.
- R7: A floating-point entry redirects to the floating-point vector (default 0x0000_0010), which is separate from the address-fault vector. It stores `cur_pc` unmodified as the return PC.
- R8: When an address fault and a qualified floating-point trap arrive in the same cycle, the address fault is taken first. The floating-point trap is held and taken at the next free cycle, even with no further request.
- R9: A return request reloads the live status bits from the backup bits, leaves the backup bits unchanged, and redirects fetch to the stored return PC.
- R10: `redir_valid` and `pipe_flush` last exactly one cycle. Address-fault, return and status-write requests presented during that cycle are ignored.
- R11: When no exception or return is taken, `stat_we` loads `stat_wdata` (bit 2 mode, bit 1 interrupt enable, bit 0 carry) into the live status bits on the next clock edge.
- R12: Priority among requests in one free cycle is: address fault, then floating-point trap, then return, then status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ae_req | input | 1 | Address-fault request for the instruction at `cur_pc` |
| cur_pc | input | 32 | PC of the instruction presenting a request |
| fp_valid | input | 1 | Floating-point cause flags are valid this cycle |
| fp_cause | input | 5 | IEEE cause flags (0 invalid, 1 div-by-zero, 2 overflow, 3 underflow, 4 inexact) |
| fp_en | input | 5 | Per-cause trap enable mask, same bit order |
| fp_unimpl | input | 1 | Unimplemented-operation cause, always traps |
| rte_req | input | 1 | Return-from-exception request |
| stat_we | input | 1 | Live status write enable |
| stat_wdata | input | 3 | Live status write data {mode, int enable, carry} |
| redir_valid | output | 1 | Fetch redirect valid |
| redir_addr | output | 32 | Fetch redirect target |
| pipe_flush | output | 1 | One-cycle pipeline flush |
| bpc | output | 32 | Stored return PC |
| stat | output | 3 | Live status {mode, int enable, carry} |
| stat_bk | output | 3 | Backup status {mode, int enable, carry} |

## Verification
On every cycle, the assertions check the following:
- the backup copy and the status update at entry;
- the clearing of the low return-PC bits on address faults;
- the reload and backup stability on return;
- the correct vector for each entry kind;
- the single-cycle redirect pulse;
- the holding of a floating-point trap that loses to an address fault.

Some behaviours need the bench's scenarios, in which a behavioural reference model is compared with the outputs on every clock. These are: the masking of unenabled causes, the bypass for unimplemented operations, the dropping of return and write requests during a flush, and the later servicing of a held trap with no new request.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef struct packed {
    logic sm;
    logic ie;
    logic c;
  } stat_t;

  typedef enum logic [2:0] {
    ACT_NONE = 3'd0,
    ACT_AE   = 3'd1,
    ACT_FP   = 3'd2,
    ACT_RTE  = 3'd3,
    ACT_WR   = 3'd4
  } act_e;

endpackage

// File: rtl/trap_fp_gate.sv
module trap_fp_gate #(
  parameter int N_CAUSE = 5
) (
  input  logic               fp_valid,
  input  logic [N_CAUSE-1:0] fp_cause,
  input  logic [N_CAUSE-1:0] fp_en,
  input  logic               fp_unimpl,
  output logic               fp_hit
);

  logic [N_CAUSE-1:0] qual;

  // per-cause qualification (R6)
  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    assign qual[i] = fp_cause[i] & fp_en[i];
  end

  assign fp_hit = fp_valid & (fp_unimpl | (|qual));

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic run,
  input  logic busy,
  input  logic ae_req,
  input  logic fp_hit,
  input  logic rte_req,
  input  logic stat_we,
  output act_e act
);

  logic pend_q, pend_d;

  // R12 priority, R10 nothing taken while flushing
  always_comb begin
    act = ACT_NONE;
    if (run && !busy) begin
      if (ae_req)               act = ACT_AE;
      else if (pend_q | fp_hit) act = ACT_FP;
      else if (rte_req)         act = ACT_RTE;
      else if (stat_we)         act = ACT_WR;
    end
  end

  always_comb begin
    pend_d = (pend_q | fp_hit) & (act != ACT_FP);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  a_r8_fp_held : assert property (@(posedge clk) disable iff (!rst_sn)
    (fp_hit && act == ACT_AE) |=> pend_q);

  a_r10_busy_idle : assert property (@(posedge clk) disable iff (!rst_sn)
    busy |-> act == ACT_NONE);

endmodule

// File: rtl/trap_state_bank.sv
module trap_state_bank
  import trap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 2
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  act_e              act,
  input  logic [ADDR_W-1:0] cur_pc,
  input  stat_t             wr_val,
  output stat_t             live_q,
  output stat_t             bk_q,
  output logic [ADDR_W-1:0] bpc_q
);

  stat_t             live_d, bk_d;
  logic [ADDR_W-1:0] bpc_d;
  logic [ADDR_W-1:0] pc_aligned;

  assign pc_aligned = {cur_pc[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};

  always_comb begin
    live_d = live_q;
    bk_d   = bk_q;
    bpc_d  = bpc_q;
    case (act)
      ACT_AE: begin
        bk_d      = live_q;
        live_d.ie = 1'b0;
        live_d.c  = 1'b0;
        bpc_d     = pc_aligned;
      end
      ACT_FP: begin
        bk_d      = live_q;
        live_d.ie = 1'b0;
        live_d.c  = 1'b0;
        bpc_d     = cur_pc;
      end
      ACT_RTE: live_d = bk_q;
      ACT_WR:  live_d = wr_val;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      live_q <= '0;
      bk_q   <= '0;
      bpc_q  <= '0;
    end else begin
      live_q <= live_d;
      bk_q   <= bk_d;
      bpc_q  <= bpc_d;
    end
  end

  a_r2_backup : assert property (@(posedge clk) disable iff (!rst_sn)
    (act == ACT_AE || act == ACT_FP) |=> bk_q == $past(live_q));

  a_r3_update : assert property (@(posedge clk) disable iff (!rst_sn)
    (act == ACT_AE || act == ACT_FP) |=>
      (!live_q.ie && !live_q.c && live_q.sm == $past(live_q.sm)));

  a_r5_align : assert property (@(posedge clk) disable iff (!rst_sn)
    act == ACT_AE |=> bpc_q[ALIGN-1:0] == '0);

  a_r9_restore : assert property (@(posedge clk) disable iff (!rst_sn)
    act == ACT_RTE |=> (live_q == $past(bk_q) && $stable(bk_q)));

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int              ADDR_W  = 32,
  parameter int              N_CAUSE = 5,
  parameter int              ALIGN   = 2,
  parameter logic [ADDR_W-1:0] AE_VEC = 32'h0000_0030,
  parameter logic [ADDR_W-1:0] FP_VEC = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ae_req,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              fp_valid,
  input  logic [N_CAUSE-1:0] fp_cause,
  input  logic [N_CAUSE-1:0] fp_en,
  input  logic              fp_unimpl,
  input  logic              rte_req,
  input  logic              stat_we,
  input  logic [2:0]        stat_wdata,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              pipe_flush,
  output logic [ADDR_W-1:0] bpc,
  output logic [2:0]        stat,
  output logic [2:0]        stat_bk
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic              fp_hit;
  act_e              act;
  stat_t             live_q, bk_q, wr_val;
  logic [ADDR_W-1:0] bpc_q;
  logic              rv_q, rv_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;

  assign wr_val = stat_t'(stat_wdata);

  trap_fp_gate #(.N_CAUSE(N_CAUSE)) u_gate (
    .fp_valid (fp_valid),
    .fp_cause (fp_cause),
    .fp_en    (fp_en),
    .fp_unimpl(fp_unimpl),
    .fp_hit   (fp_hit)
  );

  trap_arbiter u_arb (
    .clk    (clk),
    .rst_sn (rst_sn),
    .run    (rst_sn),
    .busy   (rv_q),
    .ae_req (ae_req),
    .fp_hit (fp_hit),
    .rte_req(rte_req),
    .stat_we(stat_we),
    .act    (act)
  );

  trap_state_bank #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_bank (
    .clk   (clk),
    .rst_sn(rst_sn),
    .act   (act),
    .cur_pc(cur_pc),
    .wr_val(wr_val),
    .live_q(live_q),
    .bk_q  (bk_q),
    .bpc_q (bpc_q)
  );

  // redirect next state
  always_comb begin
    rv_d  = 1'b0;
    tgt_d = tgt_q;
    case (act)
      ACT_AE:  begin rv_d = 1'b1; tgt_d = AE_VEC; end
      ACT_FP:  begin rv_d = 1'b1; tgt_d = FP_VEC; end
      ACT_RTE: begin rv_d = 1'b1; tgt_d = bpc_q;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rv_q  <= 1'b0;
      tgt_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (rv_d) tgt_q <= tgt_d;
    end
  end

  assign redir_valid = rv_q;
  assign pipe_flush  = rv_q;
  assign redir_addr  = tgt_q;
  assign bpc         = bpc_q;
  assign stat        = live_q;
  assign stat_bk     = bk_q;

  a_r4_ae_vector : assert property (@(posedge clk) disable iff (!rst_sn)
    act == ACT_AE |=> (redir_valid && redir_addr == AE_VEC));

  a_r7_fp_vector : assert property (@(posedge clk) disable iff (!rst_sn)
    act == ACT_FP |=> (redir_valid && redir_addr == FP_VEC));

  a_r9_rte_target : assert property (@(posedge clk) disable iff (!rst_sn)
    act == ACT_RTE |=> redir_addr == $past(bpc_q));

  a_r10_one_cycle : assert property (@(posedge clk) disable iff (!rst_sn)
    redir_valid |=> !redir_valid);

endmodule

// File: tb/trap_sequencer_test.sv
module trap_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ae_req, fp_valid, fp_unimpl, rte_req, stat_we;
  logic [31:0] cur_pc;
  logic [4:0]  fp_cause, fp_en;
  logic [2:0]  stat_wdata;
  logic        redir_valid, pipe_flush;
  logic [31:0] redir_addr, bpc;
  logic [2:0]  stat, stat_bk;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;  // 50 MHz

  trap_sequencer uut (
    .clk(clk), .rst_n(rst_n), .ae_req(ae_req), .cur_pc(cur_pc),
    .fp_valid(fp_valid), .fp_cause(fp_cause), .fp_en(fp_en),
    .fp_unimpl(fp_unimpl), .rte_req(rte_req), .stat_we(stat_we),
    .stat_wdata(stat_wdata), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .pipe_flush(pipe_flush), .bpc(bpc),
    .stat(stat), .stat_bk(stat_bk)
  );

  // behavioural reference model
  logic [2:0]  m_live, m_bk;
  logic [31:0] m_bpc, m_tgt;
  bit          m_rv, m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = 0; m_bk = 0; m_bpc = 0; m_tgt = 0; m_rv = 0; m_pend = 0;
    end else begin
      bit hit, busy;
      hit  = fp_valid && (fp_unimpl || ((fp_cause & fp_en) != 0));
      busy = m_rv;
      m_rv = 0;
      if (busy) begin
        m_pend = m_pend || hit;
      end else if (ae_req) begin
        m_bk = m_live; m_live = {m_live[2], 2'b00};
        m_bpc = {cur_pc[31:2], 2'b00}; m_tgt = 32'h30; m_rv = 1;
        m_pend = m_pend || hit;
      end else if (m_pend || hit) begin
        m_bk = m_live; m_live = {m_live[2], 2'b00};
        m_bpc = cur_pc; m_tgt = 32'h10; m_rv = 1; m_pend = 0;
      end else if (rte_req) begin
        m_live = m_bk; m_tgt = m_bpc; m_rv = 1;
      end else if (stat_we) begin
        m_live = stat_wdata;
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R3", "model live status", {29'd0, stat}, {29'd0, m_live});
      check("R2", "model backup status", {29'd0, stat_bk}, {29'd0, m_bk});
      check("R5", "model return pc", bpc, m_bpc);
      check("R10", "model redirect valid", {31'd0, redir_valid}, {31'd0, m_rv});
      check("R10", "model flush", {31'd0, pipe_flush}, {31'd0, m_rv});
      if (m_rv) check("R4", "model redirect target", redir_addr, m_tgt);
    end
  end

  task automatic idle_in();
    ae_req = 0; fp_valid = 0; fp_unimpl = 0; rte_req = 0; stat_we = 0;
    fp_cause = 0; fp_en = 0; stat_wdata = 0; cur_pc = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset live", {29'd0, stat}, 0);
    check("R1", "reset redirect", {31'd0, redir_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    check("R1", "post-reset bpc", bpc, 0);
    check("R1", "post-reset backup", {29'd0, stat_bk}, 0);

    // R11 status write
    stat_we = 1; stat_wdata = 3'b111; step();
    check("R11", "written status", {29'd0, stat}, 32'h7);

    // R4 R5 R2 R3 address fault at 0x06
    ae_req = 1; cur_pc = 32'h06; step();
    check("R4", "ae redirect", {31'd0, redir_valid}, 1);
    check("R4", "ae vector", redir_addr, 32'h30);
    check("R5", "aligned bpc", bpc, 32'h04);
    check("R2", "backup copy", {29'd0, stat_bk}, 32'h7);
    check("R3", "live after entry", {29'd0, stat}, 32'h4);
    // R10 requests during flush are ignored
    rte_req = 1; stat_we = 1; stat_wdata = 3'b011; ae_req = 1; step();
    check("R10", "no redirect after flush", {31'd0, redir_valid}, 0);
    check("R10", "status untouched", {29'd0, stat}, 32'h4);

    // R9 return
    rte_req = 1; step();
    check("R9", "restored status", {29'd0, stat}, 32'h7);
    check("R9", "return target", redir_addr, 32'h04);
    check("R9", "backup unchanged", {29'd0, stat_bk}, 32'h7);
    step();

    // R6 overflow (bit 2) not enabled
    fp_valid = 1; fp_cause = 5'b00100; fp_en = 5'b11011; cur_pc = 32'h1002; step();
    check("R6", "masked cause", {31'd0, redir_valid}, 0);
    // R7 enabled overflow
    fp_valid = 1; fp_cause = 5'b00100; fp_en = 5'b00100; cur_pc = 32'h1002; step();
    check("R7", "fp vector", redir_addr, 32'h10);
    check("R7", "fp bpc unaligned", bpc, 32'h1002);
    step();
    // R6 unimplemented ignores mask
    fp_valid = 1; fp_unimpl = 1; cur_pc = 32'h2000; step();
    check("R6", "unimpl traps", {31'd0, redir_valid}, 1);
    step();

    // R8 / R12 simultaneous
    ae_req = 1; fp_valid = 1; fp_cause = 5'b00001; fp_en = 5'b00001; cur_pc = 32'h3007; step();
    check("R8", "ae wins", redir_addr, 32'h30);
    check("R12", "ae bpc", bpc, 32'h3004);
    step();
    check("R8", "flush gap", {31'd0, redir_valid}, 0);
    cur_pc = 32'h4000; step();
    check("R8", "held fp taken", redir_addr, 32'h10);
    check("R8", "held fp bpc", bpc, 32'h4000);
    step();

    // R12 fp beats return
    fp_valid = 1; fp_unimpl = 1; rte_req = 1; cur_pc = 32'h5000; step();
    check("R12", "fp over return", redir_addr, 32'h10);
    step();

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      ae_req     = ($urandom_range(7) == 0);
      fp_valid   = ($urandom_range(3) == 0);
      fp_cause   = 5'($urandom);
      fp_en      = 5'($urandom);
      fp_unimpl  = ($urandom_range(15) == 0);
      rte_req    = ($urandom_range(5) == 0);
      stat_we    = ($urandom_range(5) == 0);
      stat_wdata = 3'($urandom);
      cur_pc     = $urandom;
      @(negedge clk);
    end
    idle_in();
    repeat (3) @(negedge clk);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule